// File: doc/BRIEF.md
# 8PSK Max-Log Soft Demapper with Ping-Pong Block Buffer

The block turns received 8PSK symbols into soft bit decisions for an LDPC decoder. Each accepted beat carries one symbol as signed fixed-point in-phase and quadrature samples. Both samples are clipped to a narrower word. The squared Euclidean distance to each of the eight constellation points is formed, and for every one of the three label bits the smallest distance among points where that bit is 1 is compared with the smallest among points where it is 0. The difference is scaled by an arithmetic right shift and saturated to a symmetric signed word. Only adders, subtractors and multipliers are used; no exponential or logarithm appears anywhere.

The three soft values of a symbol are stored together in one of two RAM banks, each sized for exactly one code block. When the bank being written fills, the block raises a block-valid level toward the decoder. The decoder then reads that bank one soft value per request, in order, while new symbols go into the other bank. A done pulse from the decoder hands the bank back. If both banks hold unread blocks, the input ready signal drops, so no unread block is ever overwritten.

Top module: `psk8_soft_demapper`

## Requirements
- R1: Before any metric is formed, each input sample (10-bit two's complement) is clipped to the 9-bit range [-256, 255].
- R2: The constellation has point k (k = 0..7) at angle k·45°. Its coordinates are I = {127, 90, 0, -90, -127, -90, 0, 90}[k] and Q = {0, 90, 127, 90, 0, -90, -127, -90}[k]. Its 3-bit Gray label is k XOR (k>>1), and label bit 2 is the most significant bit.
- R3: For label bit b, the raw soft value is (min d² over points whose bit b is 1) minus (min d² over points whose bit b is 0), where d² = (I-Ik)² + (Q-Qk)². The result is arithmetically shifted right by 8 (floor), so a positive value favours a 0 bit.
- R4: Each shifted soft value is saturated to the 8-bit range [-127, 127]. The code -128 is never produced.
- R5: A bank holds one code block of 2688 symbols, which is 8064 soft values. Reading returns the symbols in arrival order, and within a symbol bit 2, then bit 1, then bit 0.
- R6: blk_valid_o is high exactly while the bank at the read side holds a complete block that has not yet been released. It stays high until blk_done_i.
- R7: rd_en_i sampled high while blk_valid_o is high returns the next soft value on rd_data_o, with rd_valid_o high one cycle later. rd_en_i while blk_valid_o is low has no effect.
- R8: blk_done_i while blk_valid_o is high releases the bank and moves the read side to the other bank from the start. blk_done_i while blk_valid_o is low is ignored.
- R9: Banks alternate. While one bank is read, incoming symbols fill the other, and after a release the next full bank becomes readable.
- R10: Once both banks are reserved by unread blocks, sym_ready_o is low and no symbol is accepted. sym_ready_o returns high in the cycle after the releasing blk_done_i.
- R11: When a bank completes in the same cycle that the decoder releases the other bank, blk_valid_o stays high, sym_ready_o returns high, and no soft value is lost or altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol sample present |
| sym_ready_o | output | 1 | Block can accept a symbol |
| re_i | input | 10 | In-phase sample, two's complement |
| im_i | input | 10 | Quadrature sample, two's complement |
| blk_valid_o | output | 1 | A complete block is readable |
| rd_en_i | input | 1 | Read request for the next soft value |
| rd_data_o | output | 8 | Soft value, two's complement |
| rd_valid_o | output | 1 | rd_data_o carries a soft value |
| blk_done_i | input | 1 | Decoder releases the readable block |

## Verification
Two events can land on one clock edge: the writer stores the last symbol of a block, and the decoder releases the other bank. The bench slows the symbol feed so that the decoder finishes reading first. It counts accepted symbols and places the done pulse on the edge two cycles after the final symbol of the new block is accepted, which is when that symbol reaches the RAM. It then expects blk_valid_o to stay high and sym_ready_o to rise, and the scoreboard confirms every soft value of both blocks against an independent max-log model.

// File: rtl/psk8_pkg.sv
package psk8_pkg;
  localparam int NPTS = 8;
  localparam int BPS  = 3;
  localparam int AMP  = 127;
  localparam int DIAG = 90;

  // in-phase coordinate of point k, Q1.7 scaled
  function automatic int axis_re(int k);
    case (k & 7)
      0:       return AMP;
      1, 7:    return DIAG;
      2, 6:    return 0;
      3, 5:    return -DIAG;
      default: return -AMP;
    endcase
  endfunction

  // sin(theta) = cos(theta - 90 deg)
  function automatic int axis_im(int k);
    return axis_re(k + 6);
  endfunction

  function automatic logic [BPS-1:0] gray_lbl(int k);
    logic [BPS-1:0] v;
    v = BPS'(k);
    return v ^ (v >> 1);
  endfunction
endpackage

// File: rtl/psk8_sat.sv
module psk8_sat #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8,
  parameter bit SYMM  = 1'b0
) (
  input  logic signed [IN_W-1:0]  d_i,
  output logic signed [OUT_W-1:0] q_o
);
  localparam logic signed [IN_W-1:0] HI = IN_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [IN_W-1:0] LO = SYMM ? IN_W'(-((1 << (OUT_W-1)) - 1))
                                               : IN_W'(-(1 << (OUT_W-1)));

  always_comb begin
    if (d_i > HI)      q_o = HI[OUT_W-1:0];
    else if (d_i < LO) q_o = LO[OUT_W-1:0];
    else               q_o = d_i[OUT_W-1:0];
  end
endmodule

// File: rtl/psk8_llr_calc.sv
module psk8_llr_calc
  import psk8_pkg::*;
#(
  parameter int CLIP_W    = 9,
  parameter int LLR_W     = 8,
  parameter int LLR_SHIFT = 8
) (
  input  logic signed [CLIP_W-1:0] re_i,
  input  logic signed [CLIP_W-1:0] im_i,
  output logic [BPS*LLR_W-1:0]     llr_o
);
  localparam int DIFF_W = CLIP_W + 1;
  localparam int SQ_W   = 2 * DIFF_W;
  localparam int D2_W   = SQ_W + 1;
  localparam int RAW_W  = D2_W + 1;

  logic [D2_W-1:0] d2 [NPTS];

  for (genvar k = 0; k < NPTS; k++) begin : g_pt
    localparam logic signed [DIFF_W-1:0] CX = DIFF_W'(axis_re(k));
    localparam logic signed [DIFF_W-1:0] CY = DIFF_W'(axis_im(k));
    logic signed [DIFF_W-1:0] dx, dy;
    logic signed [SQ_W-1:0]   sx, sy;
    assign dx    = DIFF_W'(re_i) - CX;
    assign dy    = DIFF_W'(im_i) - CY;
    assign sx    = dx * dx;
    assign sy    = dy * dy;
    assign d2[k] = {1'b0, sx} + {1'b0, sy};
  end

  logic [D2_W-1:0] mn0 [BPS];
  logic [D2_W-1:0] mn1 [BPS];
  logic [BPS-1:0]  lb;

  always_comb begin
    lb = '0;
    for (int b = 0; b < BPS; b++) begin
      mn0[b] = '1;
      mn1[b] = '1;
      for (int k = 0; k < NPTS; k++) begin
        lb = gray_lbl(k);
        if (lb[b]) begin
          if (d2[k] < mn1[b]) mn1[b] = d2[k];
        end else begin
          if (d2[k] < mn0[b]) mn0[b] = d2[k];
        end
      end
    end
  end

  for (genvar b = 0; b < BPS; b++) begin : g_bit
    logic signed [RAW_W-1:0] raw, shf;
    logic signed [LLR_W-1:0] sat;
    assign raw = $signed({1'b0, mn1[b]}) - $signed({1'b0, mn0[b]});
    assign shf = raw >>> LLR_SHIFT;
    psk8_sat #(.IN_W(RAW_W), .OUT_W(LLR_W), .SYMM(1'b1)) u_sat (
      .d_i (shf),
      .q_o (sat)
    );
    assign llr_o[b*LLR_W +: LLR_W] = sat;
  end
endmodule

// File: rtl/psk8_bank_ram.sv
module psk8_bank_ram #(
  parameter int DEPTH = 2688,
  parameter int W     = 24,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/psk8_soft_demapper.sv
module psk8_soft_demapper
  import psk8_pkg::*;
#(
  parameter int IN_W      = 10,
  parameter int CLIP_W    = 9,
  parameter int LLR_W     = 8,
  parameter int LLR_SHIFT = 8,
  parameter int BLK_SYM   = 2688
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_valid_i,
  output logic             sym_ready_o,
  input  logic [IN_W-1:0]  re_i,
  input  logic [IN_W-1:0]  im_i,
  output logic             blk_valid_o,
  input  logic             rd_en_i,
  output logic [LLR_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  input  logic             blk_done_i
);
  localparam int SYM_AW = $clog2(BLK_SYM);
  localparam int WORD_W = BPS * LLR_W;
  localparam int LANE_W = $clog2(BPS);
  localparam logic [SYM_AW-1:0] LAST_SYM  = SYM_AW'(BLK_SYM - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BPS - 1);
  localparam logic [LLR_W-1:0]  NEG_CODE  = {1'b1, {(LLR_W-1){1'b0}}};

  // ---------------- input clip stage ----------------
  logic signed [CLIP_W-1:0] re_c, im_c;
  logic                     s1_v;
  logic signed [CLIP_W-1:0] s1_re, s1_im;
  logic                     accept;

  psk8_sat #(.IN_W(IN_W), .OUT_W(CLIP_W), .SYMM(1'b0)) u_clip_re (
    .d_i ($signed(re_i)),
    .q_o (re_c)
  );
  psk8_sat #(.IN_W(IN_W), .OUT_W(CLIP_W), .SYMM(1'b0)) u_clip_im (
    .d_i ($signed(im_i)),
    .q_o (im_c)
  );

  assign accept = sym_valid_i & sym_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v  <= 1'b0;
      s1_re <= '0;
      s1_im <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_re <= re_c;
        s1_im <= im_c;
      end
    end
  end

  // ---------------- metric stage ----------------
  logic [WORD_W-1:0] llr_c;
  logic              s2_v;
  logic [WORD_W-1:0] s2_word;

  psk8_llr_calc #(.CLIP_W(CLIP_W), .LLR_W(LLR_W), .LLR_SHIFT(LLR_SHIFT)) u_calc (
    .re_i  (s1_re),
    .im_i  (s1_im),
    .llr_o (llr_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v    <= 1'b0;
      s2_word <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) s2_word <= llr_c;
    end
  end

  // ---------------- bank control ----------------
  logic              acc_bank, wr_bank, rd_bank;
  logic [SYM_AW-1:0] acc_cnt, wr_cnt, rd_sym;
  logic [LANE_W-1:0] rd_lane;
  logic [1:0]        locked, full;
  logic              rd_fire, release_blk;

  assign sym_ready_o = ~locked[acc_bank];
  assign blk_valid_o = full[rd_bank];
  assign rd_fire     = rd_en_i & blk_valid_o;
  assign release_blk = blk_done_i & blk_valid_o;

  // reservation is taken at accept time so in-flight symbols always have room
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_bank <= 1'b0;
      acc_cnt  <= '0;
      locked   <= '0;
    end else begin
      if (accept) begin
        if (acc_cnt == LAST_SYM) begin
          acc_cnt          <= '0;
          acc_bank         <= ~acc_bank;
          locked[acc_bank] <= 1'b1;
        end else begin
          acc_cnt <= acc_cnt + 1'b1;
        end
      end
      if (release_blk) locked[rd_bank] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank <= 1'b0;
      wr_cnt  <= '0;
      full    <= '0;
    end else begin
      if (s2_v) begin
        if (wr_cnt == LAST_SYM) begin
          wr_cnt        <= '0;
          wr_bank       <= ~wr_bank;
          full[wr_bank] <= 1'b1;
        end else begin
          wr_cnt <= wr_cnt + 1'b1;
        end
      end
      if (release_blk) full[rd_bank] <= 1'b0;
    end
  end

  logic              rd_v_q, rd_bank_q;
  logic [LANE_W-1:0] rd_lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bank   <= 1'b0;
      rd_sym    <= '0;
      rd_lane   <= '0;
      rd_v_q    <= 1'b0;
      rd_bank_q <= 1'b0;
      rd_lane_q <= '0;
    end else begin
      rd_v_q <= rd_fire;
      if (rd_fire) begin
        rd_bank_q <= rd_bank;
        rd_lane_q <= rd_lane;
      end
      if (release_blk) begin
        rd_bank <= ~rd_bank;
        rd_sym  <= '0;
        rd_lane <= '0;
      end else if (rd_fire) begin
        if (rd_lane == LAST_LANE) begin
          rd_lane <= '0;
          rd_sym  <= (rd_sym == LAST_SYM) ? '0 : rd_sym + 1'b1;
        end else begin
          rd_lane <= rd_lane + 1'b1;
        end
      end
    end
  end

  // ---------------- storage ----------------
  logic [WORD_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    psk8_bank_ram #(.DEPTH(BLK_SYM), .W(WORD_W)) u_ram (
      .clk_i   (clk_i),
      .we_i    (s2_v && (wr_bank == b[0])),
      .waddr_i (wr_cnt),
      .wdata_i (s2_word),
      .re_i    (rd_fire && (rd_bank == b[0])),
      .raddr_i (rd_sym),
      .rdata_o (bank_rd[b])
    );
  end

  logic [WORD_W-1:0] sel_word;
  assign sel_word   = bank_rd[rd_bank_q];
  assign rd_valid_o = rd_v_q;

  // lane 0 carries label bit 2 (MSB first)
  always_comb begin
    rd_data_o = '0;
    for (int l = 0; l < BPS; l++)
      if (rd_lane_q == LANE_W'(l)) rd_data_o = sel_word[(BPS-1-l)*LLR_W +: LLR_W];
  end

  // ---------------- assertions ----------------
  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_v |-> !full[wr_bank]);  // R10
  AST_STALL_BOTH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full[0] && full[1]) |-> !sym_ready_o);  // R10
  AST_RESUME_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sym_ready_o && blk_valid_o && blk_done_i) |=> sym_ready_o);  // R10
  AST_BLK_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_o && !blk_done_i) |=> blk_valid_o);  // R6
  AST_RD_NEEDS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_en_i && blk_valid_o));  // R7
  AST_LLR_SYMMETRIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s2_v |-> (s2_word[0 +: LLR_W] != NEG_CODE && s2_word[LLR_W +: LLR_W] != NEG_CODE
              && s2_word[2*LLR_W +: LLR_W] != NEG_CODE));  // R4
endmodule

// File: tb/sim_psk8_soft_demapper.sv
module sim_psk8_soft_demapper;
  localparam int BLK = 2688;
  localparam int NBL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0, sym_ready;
  logic [9:0] re_s = '0, im_s = '0;
  logic       blk_valid, rd_en = 1'b0, rd_valid, blk_done = 1'b0;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  psk8_soft_demapper u0 (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_ready_o(sym_ready),
    .re_i(re_s), .im_i(im_s), .blk_valid_o(blk_valid), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .blk_done_i(blk_done)
  );

  typedef struct { int val; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0, acc_n = 0, rx_n = 0;

  const int PX[8] = '{127, 90, 0, -90, -127, -90, 0, 90};
  const int PY[8] = '{0, 90, 127, 90, 0, -90, -127, -90};
  const int LB[8] = '{0, 1, 3, 2, 6, 7, 5, 4};
  const int BI[16] = '{511, -512, 511, -512, 127, 90, 0, -90, -127, -90, 0, 90, 0, 255, -256, 256};
  const int BQ[16] = '{511, -512, -512, 300, 0, 90, 127, 90, 0, -90, -127, -90, 0, 255, -256, 0};

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clipv(int v);
    return (v > 255) ? 255 : (v < -256) ? -256 : v;
  endfunction

  function automatic int raw_llr(int re, int im, int b);
    int ci, cq, m0, m1, d;
    ci = clipv(re); cq = clipv(im);
    m0 = 32'h7fffffff; m1 = 32'h7fffffff;
    for (int k = 0; k < 8; k++) begin
      d = (ci - PX[k]) * (ci - PX[k]) + (cq - PY[k]) * (cq - PY[k]);
      if (((LB[k] >> b) & 1) == 1) begin if (d < m1) m1 = d; end
      else begin if (d < m0) m0 = d; end
    end
    return (m1 - m0) >>> 8;
  endfunction

  task automatic send(int re, int im, bit exact);
    int r;
    bit sat;
    string tag;
    sat = 1'b0;
    for (int b = 2; b >= 0; b--) begin
      r = raw_llr(re, im, b);
      if (r > 127 || r < -127) sat = 1'b1;
    end
    if (clipv(re) != re || clipv(im) != im) tag = "R1";
    else if (exact) tag = "R2";
    else if (sat) tag = "R4";
    else tag = "R3";
    for (int b = 2; b >= 0; b--) begin
      r = raw_llr(re, im, b);
      r = (r > 127) ? 127 : (r < -127) ? -127 : r;
      sb.push_back('{r, tag});
    end
    sym_valid = 1'b1; re_s = 10'(re); im_s = 10'(im);
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
    acc_n++;
  endtask

  task automatic driver();
    int re, im;
    for (int blk = 0; blk < NBL; blk++) begin
      for (int s = 0; s < BLK; s++) begin
        if (blk == 0 && s < 16) send(BI[s], BQ[s], (s >= 4 && s < 12));
        else begin
          if ((s & 3) == 0) begin
            re = int'($urandom_range(1023)) - 512; im = int'($urandom_range(1023)) - 512;
          end else begin
            re = int'($urandom_range(400)) - 200; im = int'($urandom_range(400)) - 200;
          end
          send(re, im, 1'b0);
        end
        if (blk == 2) repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic read_block();
    while (!blk_valid) @(negedge clk);
    for (int n = 0; n < 3 * BLK; n++) begin
      if (n % 7 == 3) begin rd_en = 1'b0; @(negedge clk); end
      rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0;
  endtask

  task automatic release_blk();
    blk_done = 1'b1;
    @(negedge clk);
    blk_done = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      exp_t e;
      rx_n++;
      if (sb.size() == 0) chk(1'b0, "R5", "unexpected soft value", $signed(rd_data), 0);
      else begin
        e = sb.pop_front();
        chk($signed(rd_data) == e.val, e.tag, $sformatf("soft value #%0d", rx_n),
            $signed(rd_data), e.val);
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", rx_n, NBL * 3 * BLK);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sym_ready == 1'b1, "R10", "ready in reset", sym_ready, 1);
    chk(blk_valid == 1'b0, "R6", "blk_valid in reset", blk_valid, 0);
    chk(rd_valid == 1'b0, "R7", "rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // stray read and done with nothing stored
    rd_en = 1'b1; blk_done = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_valid == 1'b0, "R7", "read ignored when no block", rd_valid, 0);
    chk(blk_valid == 1'b0, "R8", "done ignored when no block", blk_valid, 0);
    chk(sym_ready == 1'b1, "R8", "ready after stray done", sym_ready, 1);
    rd_en = 1'b0; blk_done = 1'b0;
    fork driver(); join_none
    // decoder idle: both banks fill, input must stall
    wait (acc_n == 2 * BLK);
    repeat (30) @(negedge clk);
    chk(sym_ready == 1'b0, "R10", "ready low with both banks unread", sym_ready, 0);
    chk(acc_n == 2 * BLK, "R10", "no symbol accepted while stalled", acc_n, 2 * BLK);
    chk(blk_valid == 1'b1, "R6", "blk_valid held without done", blk_valid, 1);
    read_block();
    release_blk();
    chk(sym_ready == 1'b1, "R10", "ready after release", sym_ready, 1);
    chk(blk_valid == 1'b1, "R9", "second bank readable after release", blk_valid, 1);
    read_block();
    chk(acc_n < 3 * BLK, "R11", "read finished before fill", acc_n, 3 * BLK - 1);
    wait (acc_n == 3 * BLK);
    @(negedge clk);
    blk_done = 1'b1;      // lands on the edge that stores the last symbol
    @(negedge clk);
    blk_done = 1'b0;
    chk(blk_valid == 1'b1, "R11", "blk_valid across fill+release", blk_valid, 1);
    chk(sym_ready == 1'b1, "R11", "ready across fill+release", sym_ready, 1);
    read_block();
    release_blk();
    read_block();
    release_blk();
    repeat (5) @(negedge clk);
    chk(blk_valid == 1'b0, "R6", "blk_valid low when all released", blk_valid, 0);
    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    chk(rx_n == NBL * 3 * BLK, "R5", "soft values read", rx_n, NBL * 3 * BLK);
    summary();
    $finish;
  end
endmodule